// File: doc/BRIEF.md
# Carrier Replica and Wipe-off Correlator

This block is the hardware side of one carrier tracking channel in a satellite navigation receiver. Each enabled clock cycle it takes one signed digital IF sample and one prompt code chip. A phase-accumulator oscillator builds cosine and sine replicas of the carrier. The sample is multiplied by both replicas to strip the carrier, giving an in-phase arm and a quadrature arm. Both arms are then multiplied by the prompt chip to strip the spreading code.

Each arm is summed over a programmable number of samples. At the end of the interval the block dumps one prompt I/Q pair with a single-cycle strobe. The oscillator's frequency word is the wrapping sum of three terms: a fixed bias, the loop-filter output from software, and an optional external velocity-aiding term. A scaled copy of the loop-filter output is sent to the code loop as carrier aiding.

Control is a two-state machine. `ST_IDLE` holds the phase and keeps the sums and sample count clear. `ST_INTEG` integrates samples. The transition *start* (IDLE to INTEG) fires on the edge that takes the first enabled sample. The transition *abort* (INTEG to IDLE) fires when `en` is sampled low. The end of an interval (*dump*) is an event inside `ST_INTEG`, not a separate state.

Top module: `carrier_wipe_correlator`

## Requirements
- R1: While reset is asserted and after it is released, `ip_out`, `qp_out` and `dump_vld` are zero, and the carrier phase starts at zero.
- R2: On every enabled sample, the phase advances by `bias_word + filt_word + aid_word`, summed modulo 2^32, when `aid_en` is 1.
- R3: When `aid_en` is 0, `aid_word` has no effect on the phase, so the I/Q results equal those of an unaided channel.
- R4: The top 3 phase bits k select the replica values. Sine is {1,2,2,1,-1,-2,-2,-1} and cosine is {2,1,-1,-2,-2,-1,1,2}, for k = 0..7. The I arm is IF × cosine and the Q arm is IF × sine.
- R5: A `code_chip` of 1 stands for -1 and negates both arm products. A value of 0 stands for +1.
- R6: Each interval sums exactly `dump_len` enabled samples per arm. The sums appear on `ip_out`/`qp_out` on the clock edge that takes the last sample. A `dump_len` of 0 behaves as 1.
- R7: `dump_vld` is high for exactly the one cycle after each interval's last sample. The next interval begins with the very next enabled sample, with no sample lost and none counted twice.
- R8: A cycle with `en` low takes no sample and holds the phase. It discards the partial sums, restarts the sample count and returns the controller to `ST_IDLE`.
- R9: `code_aid` equals `filt_word` arithmetically shifted right by `AID_SHIFT` (default 4). It follows `filt_word` combinationally.
- R10: `ip_out` and `qp_out` hold their last dumped values between dumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per enabled cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Sample-valid / channel run |
| aid_en | input | 1 | 1 = add external aiding to frequency word |
| bias_word | input | 32 | Nominal carrier frequency word |
| filt_word | input | 32 | Signed loop-filter output |
| aid_word | input | 32 | Signed external velocity-aiding term |
| dump_len | input | 16 | Samples per integration interval (0 acts as 1) |
| if_sample | input | 4 | Signed IF sample |
| code_chip | input | 1 | Prompt chip, 1 = -1 |
| ip_out | output | 24 | Signed prompt in-phase sum |
| qp_out | output | 24 | Signed prompt quadrature sum |
| dump_vld | output | 1 | One-cycle strobe marking a new I/Q pair |
| code_aid | output | 32 | Scaled carrier aiding to code loop |

## Verification
A sample driven in cycle n uses the phase held in that cycle. An interval's sums and strobe are registered on the rising edge that takes its last sample, and the phase update for cycle n is visible from cycle n+1. The bench therefore drives inputs on the falling edge. On the next falling edge, after that single register stage, it compares `ip_out`, `qp_out` and `dump_vld` with a reference model that it has stepped once. `code_aid` has no register on its path, so it is compared 1 ns after `filt_word` is driven, inside the same cycle.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
    localparam int AMP_W    = 3;
    localparam int LUT_BITS = 3;

    typedef enum logic [0:0] {ST_IDLE, ST_INTEG} cwc_state_t;
    typedef logic signed [AMP_W-1:0] amp_t;

    function automatic amp_t sin_map(input logic [LUT_BITS-1:0] k);
        amp_t v;
        unique case (k)
            3'd0: v = 3'sd1;
            3'd1: v = 3'sd2;
            3'd2: v = 3'sd2;
            3'd3: v = 3'sd1;
            3'd4: v = -3'sd1;
            3'd5: v = -3'sd2;
            3'd6: v = -3'sd2;
            3'd7: v = -3'sd1;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic amp_t cos_map(input logic [LUT_BITS-1:0] k);
        amp_t v;
        unique case (k)
            3'd0: v = 3'sd2;
            3'd1: v = 3'sd1;
            3'd2: v = -3'sd1;
            3'd3: v = -3'sd2;
            3'd4: v = -3'sd2;
            3'd5: v = -3'sd1;
            3'd6: v = 3'sd1;
            3'd7: v = 3'sd2;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/cwc_nco.sv
module cwc_nco
    import cwc_pkg::*;
#(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic [PH_W-1:0] fw,
    output amp_t            sin_o,
    output amp_t            cos_o
);
    logic [PH_W-1:0]     phase;
    logic [LUT_BITS-1:0] idx;

    assign idx = phase[PH_W-1 -: LUT_BITS];

    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (step_en) phase <= phase + fw;
    end

    assign sin_o = sin_map(idx);
    assign cos_o = cos_map(idx);

    // R8: no sample, no phase movement
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(phase));

    // R2: phase steps by the word present with the sample
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (phase == $past(phase) + $past(fw)));
endmodule

// File: rtl/cwc_wipe.sv
module cwc_wipe
    import cwc_pkg::*;
#(
    parameter int IF_W = 4,
    parameter int P_W  = IF_W + AMP_W
) (
    input  logic signed [IF_W-1:0] if_s,
    input  amp_t                   cos_i,
    input  amp_t                   sin_i,
    input  logic                   chip,
    output logic signed [P_W-1:0]  prod_i,
    output logic signed [P_W-1:0]  prod_q
);
    amp_t                  rep  [2];
    logic signed [P_W-1:0] prod [2];

    assign rep[0] = cos_i;
    assign rep[1] = sin_i;

    for (genvar a = 0; a < 2; a++) begin : g_arm
        logic signed [P_W-1:0] ext_if;
        logic signed [P_W-1:0] ext_rep;
        logic signed [P_W-1:0] carr_off;
        assign ext_if   = {{(P_W-IF_W){if_s[IF_W-1]}}, if_s};
        assign ext_rep  = {{(P_W-AMP_W){rep[a][AMP_W-1]}}, rep[a]};
        assign carr_off = ext_if * ext_rep;
        assign prod[a]  = chip ? -carr_off : carr_off;
    end

    assign prod_i = prod[0];
    assign prod_q = prod[1];
endmodule

// File: rtl/cwc_ctrl.sv
module cwc_ctrl
    import cwc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] len,
    output logic             take,
    output logic             last
);
    cwc_state_t       state, state_n;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (en)  state_n = ST_INTEG;
            ST_INTEG: if (!en) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
        take = en;
        last = en && (cnt_inc >= {1'b0, len});
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (!en)  cnt <= '0;
        else if (last) cnt <= '0;
        else           cnt <= cnt_inc[CNT_W-1:0];
    end

    // R8: idle means a fresh count
    a_r8_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));
endmodule

// File: rtl/cwc_accum.sv
module cwc_accum #(
    parameter int P_W   = 7,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    last,
    input  logic signed [P_W-1:0]   prod,
    output logic signed [ACC_W-1:0] dump_o
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum;

    assign sum = acc + {{(ACC_W-P_W){prod[P_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            dump_o <= '0;
        end else if (!take) begin
            acc <= '0;
        end else if (last) begin
            dump_o <= sum;
            acc    <= '0;
        end else begin
            acc <= sum;
        end
    end

    // R10: output moves only on a dump
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(dump_o));

    // R8: a gap discards the partial sum
    a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (acc == '0));
endmodule

// File: rtl/carrier_wipe_correlator.sv
module carrier_wipe_correlator
    import cwc_pkg::*;
#(
    parameter int IF_W      = 4,
    parameter int PH_W      = 32,
    parameter int ACC_W     = 24,
    parameter int CNT_W     = 16,
    parameter int AID_SHIFT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    aid_en,
    input  logic [PH_W-1:0]         bias_word,
    input  logic signed [PH_W-1:0]  filt_word,
    input  logic signed [PH_W-1:0]  aid_word,
    input  logic [CNT_W-1:0]        dump_len,
    input  logic signed [IF_W-1:0]  if_sample,
    input  logic                    code_chip,
    output logic signed [ACC_W-1:0] ip_out,
    output logic signed [ACC_W-1:0] qp_out,
    output logic                    dump_vld,
    output logic signed [PH_W-1:0]  code_aid
);
    localparam int P_W = IF_W + AMP_W;

    logic [PH_W-1:0]         fw;
    logic [PH_W-1:0]         aid_term;
    amp_t                    sin_r, cos_r;
    logic                    take, last;
    logic signed [P_W-1:0]   arm_prod [2];
    logic signed [ACC_W-1:0] arm_dump [2];

    assign aid_term = aid_en ? $unsigned(aid_word) : '0;
    assign fw       = bias_word + $unsigned(filt_word) + aid_term;
    assign code_aid = filt_word >>> AID_SHIFT;

    cwc_nco #(.PH_W(PH_W)) i_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (take),
        .fw      (fw),
        .sin_o   (sin_r),
        .cos_o   (cos_r)
    );

    cwc_wipe #(.IF_W(IF_W), .P_W(P_W)) i_wipe (
        .if_s   (if_sample),
        .cos_i  (cos_r),
        .sin_i  (sin_r),
        .chip   (code_chip),
        .prod_i (arm_prod[0]),
        .prod_q (arm_prod[1])
    );

    cwc_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .len   (dump_len),
        .take  (take),
        .last  (last)
    );

    for (genvar a = 0; a < 2; a++) begin : g_acc
        cwc_accum #(.P_W(P_W), .ACC_W(ACC_W)) i_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (take),
            .last   (last),
            .prod   (arm_prod[a]),
            .dump_o (arm_dump[a])
        );
    end

    assign ip_out = arm_dump[0];
    assign qp_out = arm_dump[1];

    always_ff @(posedge clk) begin
        if (!rst_n) dump_vld <= 1'b0;
        else        dump_vld <= last;
    end

    // R7: a strobe always follows an enabled sample
    a_r7_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
        dump_vld |-> $past(en && rst_n));
endmodule

// File: tb/test_carrier_wipe_correlator.sv
module test_carrier_wipe_correlator;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic               aid_en = 1'b0;
    logic [31:0]        bias_word = '0;
    logic signed [31:0] filt_word = '0;
    logic signed [31:0] aid_word = '0;
    logic [15:0]        dump_len = 16'd1;
    logic signed [3:0]  if_sample = '0;
    logic               code_chip = 1'b0;
    logic signed [23:0] ip_out, qp_out;
    logic               dump_vld;
    logic signed [31:0] code_aid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur = "R1";

    logic [31:0] m_ph = '0;
    int m_ai = 0, m_aq = 0, m_cnt = 0;
    int exp_i = 0, exp_q = 0;
    bit exp_v = 1'b0;

    always #5 clk = ~clk;

    carrier_wipe_correlator i_carrier_wipe_correlator (
        .clk(clk), .rst_n(rst_n), .en(en), .aid_en(aid_en),
        .bias_word(bias_word), .filt_word(filt_word), .aid_word(aid_word),
        .dump_len(dump_len), .if_sample(if_sample), .code_chip(code_chip),
        .ip_out(ip_out), .qp_out(qp_out), .dump_vld(dump_vld), .code_aid(code_aid)
    );

    function automatic int tsin(input int k);
        int m = ((k % 4) == 0 || (k % 4) == 3) ? 1 : 2;
        return (k < 4) ? m : -m;
    endfunction

    function automatic int tcos(input int k);
        return tsin((k + 2) % 8);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic compare_outs();
        chk(int'(ip_out) == exp_i, cur, "ip_out", ip_out, exp_i);
        chk(int'(qp_out) == exp_q, cur, "qp_out", qp_out, exp_q);
        chk(dump_vld == exp_v, "R7", "dump_vld", dump_vld, exp_v);
    endtask

    task automatic step(input bit e, input int ifv, input bit ch);
        int k, pi, pq;
        logic signed [31:0] want_aid;
        compare_outs();
        en = e;
        if_sample = 4'(ifv);
        code_chip = ch;
        #1;
        want_aid = filt_word >>> 4;
        chk(code_aid == want_aid, "R9", "code_aid", code_aid, want_aid);
        if (e) begin
            k  = int'(m_ph[31:29]);
            pi = ifv * tcos(k);
            pq = ifv * tsin(k);
            if (ch) begin pi = -pi; pq = -pq; end
            if (m_cnt + 1 >= int'(dump_len)) begin
                exp_i = m_ai + pi; exp_q = m_aq + pq; exp_v = 1'b1;
                m_ai = 0; m_aq = 0; m_cnt = 0;
            end else begin
                m_ai += pi; m_aq += pq; m_cnt++; exp_v = 1'b0;
            end
            m_ph = m_ph + bias_word + filt_word + (aid_en ? aid_word : 32'd0);
        end else begin
            m_ai = 0; m_aq = 0; m_cnt = 0; exp_v = 1'b0;
        end
        @(negedge clk);
    endtask

    function automatic int rnd_if();
        return int'($urandom_range(15)) - 8;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        cur = "R1";
        compare_outs();
        rst_n = 1'b1;

        // R4: one table step per sample, unit IF, interval of 1
        cur = "R4";
        bias_word = 32'h2000_0000;
        for (int i = 0; i < 16; i++) step(1'b1, 1, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b1, -3, 1'b0);

        // R5: negative chips
        cur = "R5";
        for (int i = 0; i < 16; i++) step(1'b1, 5, i[0]);

        // R3: aiding present but disabled
        cur = "R3";
        aid_word = 32'sh1357_9BDF; aid_en = 1'b0;
        for (int i = 0; i < 12; i++) step(1'b1, rnd_if(), 1'b0);

        // R2: all three terms with a wrapping sum
        cur = "R2";
        bias_word = 32'hF000_0000; filt_word = 32'sh1800_0000;
        aid_word = 32'sh0A00_0000; aid_en = 1'b1;
        for (int i = 0; i < 16; i++) step(1'b1, rnd_if(), 1'(i % 3 == 0));
        filt_word = -32'sh0300_0000;
        for (int i = 0; i < 8; i++) step(1'b1, 2, 1'b0);

        // R6 / R7: longer intervals back to back, then length 0
        cur = "R6";
        dump_len = 16'd5;
        for (int i = 0; i < 25; i++) step(1'b1, rnd_if(), 1'($urandom_range(1)));
        dump_len = 16'd0;
        for (int i = 0; i < 6; i++) step(1'b1, rnd_if(), 1'b0);
        cur = "R7";
        dump_len = 16'd2;
        for (int i = 0; i < 10; i++) step(1'b1, 7, 1'b0);

        // R8: gaps mid-interval discard and restart; R10: outputs hold
        cur = "R8";
        dump_len = 16'd4;
        step(1'b1, 6, 1'b0); step(1'b1, 6, 1'b0);
        step(1'b0, 7, 1'b0); step(1'b0, -8, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b1, 3, 1'b0);
        cur = "R10";
        for (int i = 0; i < 6; i++) step(1'b0, rnd_if(), 1'b0);

        // randomized mix
        cur = "R6";
        bias_word = $urandom();
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(19) == 0) filt_word = $signed($urandom()) >>> 6;
            if ($urandom_range(19) == 0) aid_word = $urandom();
            if ($urandom_range(29) == 0) aid_en = 1'($urandom_range(1));
            if ($urandom_range(49) == 0) dump_len = 16'($urandom_range(9));
            step(1'($urandom_range(9) != 0), rnd_if(), 1'($urandom_range(1)));
        end
        compare_outs();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule